// File: doc/BRIEF.md
# Port-Mapped Serial Transceiver with Receive Interrupt

This block connects an asynchronous serial line to a CPU's I/O port bus. It sends and receives 8-bit characters framed with one start bit and one stop bit and no parity. The bit rate comes from the system clock frequency and the baud rate, which are both parameters. The receiver oversamples the line at sixteen times the bit rate. It confirms a start bit at the middle of the bit before it commits to a frame, and it keeps the last byte it accepted. The transmitter shifts out one byte per frame.

The CPU uses three fixed port numbers. A read of port 64 returns the last received byte. A read of port 65 returns the transmitter busy flag. A write to port 66 hands a byte to the transmitter. A valid reception raises the interrupt request line for CPU interrupt 1. That line stays high until software reads the received byte or acknowledges the interrupt.

The port bus has no valid/ready handshake, and the block never applies back-pressure. A write is accepted in the cycle it is presented when the transmitter is idle, and it is dropped otherwise. Software is expected to poll port 65 before writing. Reads are combinational, and only the read strobe qualifies them.

Top module: `uart_port_io`

## Requirements
- R1: The serial output idles high. A frame is a low start bit, then eight data bits sent least significant bit first, then a high stop bit. Each bit lasts 16*D clock cycles, where D = (CLK_HZ + 8*BAUD) / (16*BAUD) using integer division.
- R2: A write to port 66 (io_wr high, io_addr = 66) while the transmitter is idle drives txd low from the next clock edge. The byte sent is io_wdata[7:0].
- R3: A write to port 66 while the transmitter is busy has no effect on the frame in progress, and it starts no later frame.
- R4: Reading port 65 returns 16'h0001 while the transmitter is busy and 16'h0000 while it is idle. Busy rises at the accepting write's clock edge and falls exactly 10 bit periods later.
- R5: Reading port 64 returns the most recently received valid byte, zero-extended to 16 bits. It reads 0 after reset.
- R6: A low pulse on rxd that is high again by the middle of the start bit (8 oversample ticks) is discarded. It raises no interrupt and leaves the received byte unchanged.
- R7: A frame whose stop bit samples low is discarded. It raises no interrupt and leaves the received byte unchanged, and the receiver waits for the line to go high before it looks for a new start bit.
- R8: A valid reception raises irq1. irq1 stays high until a read of port 64 or a pulse on irq_ack, and it falls at the clock edge after that read or pulse.
- R9: io_rdata is 0 when io_rd is low or io_addr is not 64 or 65. Its upper 8 bits are always 0.
- R10: While reset is active, txd is 1, irq1 is 0, the transmitter is idle, and the held received byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O port number |
| io_rd | input | 1 | Port read strobe |
| io_wr | input | 1 | Port write strobe |
| io_wdata | input | DATA_W | Port write data |
| io_rdata | output | DATA_W | Port read data (combinational) |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq1 | output | 1 | Receive interrupt request |
| rxd | input | 1 | Serial receive line (asynchronous) |
| txd | output | 1 | Serial transmit line |

## Verification
The assertions check the rules that hold on every cycle. The line is high whenever the transmitter is idle, an accepted write starts a low start bit, busy never rises without a write, the interrupt follows its set and clear conditions, the held byte changes only on a completed frame, and read data stays zero-extended. Only the bench scenarios can show the rest. These are the exact bit order and bit length on txd, a write being dropped during a frame, glitch rejection, the discarding of frames with a bad stop bit, and the byte value seen at port 64 after each kind of frame.

// File: rtl/uart_port_pkg.sv
package uart_port_pkg;
  localparam int OS_RATE = 16;
  localparam int OS_W    = $clog2(OS_RATE);
  localparam int FRAME_BITS = 10;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_BREAK
  } rx_state_e;

  function automatic int calc_os_div(input int clk_hz, input int baud);
    int d;
    d = (clk_hz + baud * (OS_RATE / 2)) / (baud * OS_RATE);
    return (d < 1) ? 1 : d;
  endfunction
endpackage

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = !clr && (cnt == LAST);
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_port_pkg::*;
#(
  parameter int OS_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] data,
  output logic       txd,
  output logic       busy
);
  localparam logic [OS_W-1:0] OS_LAST   = OS_W'(OS_RATE - 1);
  localparam logic [3:0]      IDX_LAST  = 4'(FRAME_BITS - 1);
  localparam logic [3:0]      IDX_LASTD = 4'(FRAME_BITS - 2);

  logic            tick;
  logic [OS_W-1:0] os_cnt;
  logic [3:0]      bit_idx;
  logic [7:0]      shreg;

  uart_tick_gen #(.DIV(OS_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (!busy),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      txd     <= 1'b1;
      os_cnt  <= '0;
      bit_idx <= '0;
      shreg   <= '0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        txd     <= 1'b0;
        shreg   <= data;
        os_cnt  <= '0;
        bit_idx <= '0;
      end
    end else if (tick) begin
      if (os_cnt == OS_LAST) begin
        os_cnt <= '0;
        if (bit_idx == IDX_LAST) begin
          busy <= 1'b0;
          txd  <= 1'b1;
        end else begin
          bit_idx <= bit_idx + 1'b1;
          txd     <= (bit_idx == IDX_LASTD) ? 1'b1 : shreg[0];
          shreg   <= {1'b0, shreg[7:1]};
        end
      end else begin
        os_cnt <= os_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_port_pkg::*;
#(
  parameter int OS_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  output logic       done,
  output logic [7:0] byte_out
);
  localparam logic [OS_W-1:0] OS_LAST  = OS_W'(OS_RATE - 1);
  localparam logic [OS_W-1:0] MID_LAST = OS_W'(OS_RATE / 2 - 1);

  rx_state_e       state;
  logic [1:0]      sync;
  logic            rx_s;
  logic            tick;
  logic [OS_W-1:0] os_cnt;
  logic [2:0]      bit_cnt;
  logic [7:0]      shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};
  end
  assign rx_s = sync[1];

  uart_tick_gen #(.DIV(OS_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (state == RX_IDLE),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= RX_IDLE;
      os_cnt   <= '0;
      bit_cnt  <= '0;
      shreg    <= '0;
      done     <= 1'b0;
      byte_out <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        RX_IDLE: begin
          os_cnt <= '0;
          if (!rx_s) state <= RX_START;
        end
        RX_START: if (tick) begin
          if (os_cnt == MID_LAST) begin
            os_cnt  <= '0;
            bit_cnt <= '0;
            state   <= rx_s ? RX_IDLE : RX_DATA;
          end else begin
            os_cnt <= os_cnt + 1'b1;
          end
        end
        RX_DATA: if (tick) begin
          if (os_cnt == OS_LAST) begin
            os_cnt <= '0;
            shreg  <= {rx_s, shreg[7:1]};
            if (bit_cnt == 3'd7) state <= RX_STOP;
            bit_cnt <= bit_cnt + 1'b1;
          end else begin
            os_cnt <= os_cnt + 1'b1;
          end
        end
        RX_STOP: if (tick) begin
          if (os_cnt == OS_LAST) begin
            os_cnt <= '0;
            if (rx_s) begin
              done     <= 1'b1;
              byte_out <= shreg;
              state    <= RX_IDLE;
            end else begin
              state <= RX_BREAK;
            end
          end else begin
            os_cnt <= os_cnt + 1'b1;
          end
        end
        RX_BREAK: if (rx_s) state <= RX_IDLE;
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_port_io.sv
module uart_port_io
  import uart_port_pkg::*;
#(
  parameter int CLK_HZ    = 200_000_000,
  parameter int BAUD      = 115_200,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int PORT_RXD  = 64,
  parameter int PORT_STAT = 65,
  parameter int PORT_TXD  = 66
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  input  logic              irq_ack,
  output logic              irq1,
  input  logic              rxd,
  output logic              txd
);
  localparam int OS_DIV = calc_os_div(CLK_HZ, BAUD);
  localparam logic [ADDR_W-1:0] A_RXD  = ADDR_W'(PORT_RXD);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(PORT_STAT);
  localparam logic [ADDR_W-1:0] A_TXD  = ADDR_W'(PORT_TXD);

  logic       wr_tx, rd_rx, rd_stat;
  logic       tx_busy;
  logic       rx_done;
  logic [7:0] rx_byte;
  logic [7:0] rx_hold;

  assign wr_tx   = io_wr && (io_addr == A_TXD);
  assign rd_rx   = io_rd && (io_addr == A_RXD);
  assign rd_stat = io_rd && (io_addr == A_STAT);

  uart_tx_core #(.OS_DIV(OS_DIV)) u_tx (
    .clk  (clk),
    .rst_n(rst_n),
    .start(wr_tx),
    .data (io_wdata[7:0]),
    .txd  (txd),
    .busy (tx_busy)
  );

  uart_rx_core #(.OS_DIV(OS_DIV)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .rxd     (rxd),
    .done    (rx_done),
    .byte_out(rx_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_hold <= '0;
      irq1    <= 1'b0;
    end else begin
      if (rx_done) rx_hold <= rx_byte;
      if (rx_done) irq1 <= 1'b1;
      else if (rd_rx || irq_ack) irq1 <= 1'b0;
    end
  end

  always_comb begin
    io_rdata = '0;
    if (rd_rx)        io_rdata = {{(DATA_W-8){1'b0}}, rx_hold};
    else if (rd_stat) io_rdata = {{(DATA_W-1){1'b0}}, tx_busy};
  end
endmodule

// File: rtl/uart_port_io_chk.sv
module uart_port_io_chk #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int PORT_RXD  = 64,
  parameter int PORT_TXD  = 66
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_rd,
  input logic              io_wr,
  input logic [DATA_W-1:0] io_rdata,
  input logic              irq_ack,
  input logic              irq1,
  input logic              txd,
  input logic              tx_busy,
  input logic              rx_done,
  input logic [7:0]        rx_hold
);
  logic wr_t, rd_r;
  assign wr_t = io_wr && (io_addr == ADDR_W'(PORT_TXD));
  assign rd_r = io_rd && (io_addr == ADDR_W'(PORT_RXD));

  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  a_r2_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_t && !tx_busy) |=> (tx_busy && !txd));

  a_r4_busy_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && !wr_t) |=> !tx_busy);

  a_r8_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> irq1);

  a_r8_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_r || irq_ack) && !rx_done) |=> !irq1);

  a_r8_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_r && !irq_ack && !rx_done) |=> (irq1 == $past(irq1)));

  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done |=> $stable(rx_hold));

  a_r9_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    io_rdata[DATA_W-1:8] == '0);
endmodule

bind uart_port_io uart_port_io_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .PORT_RXD(PORT_RXD),
  .PORT_TXD(PORT_TXD)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .io_addr (io_addr),
  .io_rd   (io_rd),
  .io_wr   (io_wr),
  .io_rdata(io_rdata),
  .irq_ack (irq_ack),
  .irq1    (irq1),
  .txd     (txd),
  .tx_busy (tx_busy),
  .rx_done (rx_done),
  .rx_hold (rx_hold)
);

// File: tb/uart_port_io_test.sv
`timescale 1ns/1ps
module uart_port_io_test;
  localparam int CLK_HZ = 7_372_800;
  localparam int BAUD   = 115_200;
  localparam int D      = (CLK_HZ + 8 * BAUD) / (16 * BAUD);
  localparam int BIT    = 16 * D;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  io_addr = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0, irq_ack = 1'b0;
  logic [15:0] io_wdata = '0;
  logic [15:0] io_rdata;
  logic        irq1, txd;
  logic        rxd = 1'b1;

  int checks = 0, errors = 0, cycles = 0;

  // reference model state
  bit         tx_act = 0, was_act = 0;
  int         t = 0;
  logic [9:0] frame = '1;
  logic [7:0] rx_m = '0;
  bit         irq_m = 0;
  bit         skip = 0;

  uart_port_io #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd),
    .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .irq_ack(irq_ack), .irq1(irq1), .rxd(rxd), .txd(txd)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      tx_act = 0; t = 0; rx_m = '0; irq_m = 0;
    end else begin
      was_act = tx_act;
      if (tx_act) begin
        t++;
        if (t == 10 * BIT) tx_act = 0;
      end
      if (io_wr && io_addr == 8'd66 && !was_act) begin
        tx_act = 1; t = 0; frame = {1'b1, io_wdata[7:0], 1'b0};
      end
      if ((io_rd && io_addr == 8'd64) || irq_ack) irq_m = 0;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    #0.5;
    if (rst_n) begin
      check("R1 txd waveform", txd, tx_act ? frame[t / BIT] : 1'b1);
      if (!skip) check("R8 irq1 level", irq1, irq_m);
      if (!io_rd)                  check("R9 idle rdata", io_rdata, 0);
      else if (io_addr == 8'd64)   check("R5 rdata rx", io_rdata, rx_m);
      else if (io_addr == 8'd65)   check("R4 rdata busy", io_rdata, tx_act);
      else                         check("R9 other port", io_rdata, 0);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic port_write(input logic [7:0] a, input logic [15:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic port_read(input logic [7:0] a, input int exp, input string tag);
    io_addr = a; io_rd = 1'b1;
    #1 check(tag, io_rdata, exp);
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic send_rx(input logic [7:0] b, input bit good_stop);
    logic [9:0] f;
    f = {good_stop, b, 1'b0};
    skip = 1;
    for (int i = 0; i < 10; i++) begin
      rxd = f[i];
      wait_cyc(BIT);
    end
    rxd = 1'b1;
    wait_cyc(BIT);
    if (good_stop) begin
      rx_m = b;
      irq_m = 1;
    end
    skip = 0;
  endtask

  initial begin
    @(negedge clk);
    #1;
    check("R10 txd in reset", txd, 1);
    check("R10 irq1 in reset", irq1, 0);
    wait_cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    port_read(8'd65, 0, "R10 idle after reset");
    port_read(8'd64, 0, "R10 rx byte after reset");

    // R2: transmit A5, first bit low next edge
    port_write(8'd66, 16'h12A5);
    #1 check("R2 start bit low", txd, 0);
    port_read(8'd65, 1, "R4 busy during frame");
    wait_cyc(3 * BIT);
    // R3: write while busy must not alter or queue
    port_write(8'd66, 16'h003C);
    wait_cyc(7 * BIT);
    port_read(8'd65, 0, "R3 ignored write started nothing");
    wait_cyc(2 * BIT);
    check("R3 line idle after ignored write", txd, 1);

    // R1: other patterns
    port_write(8'd66, 16'h0000);
    wait_cyc(11 * BIT);
    port_write(8'd66, 16'h00FF);
    wait_cyc(11 * BIT);
    port_write(8'd66, 16'h0081);
    wait_cyc(11 * BIT);

    // R5/R8: receive, cleared by reading port 64
    send_rx(8'h5A, 1'b1);
    check("R8 irq after rx", irq1, 1);
    port_read(8'd64, 16'h005A, "R5 received 5A");
    #1 check("R8 irq cleared by read", irq1, 0);

    // R8: cleared by ack
    send_rx(8'hC3, 1'b1);
    check("R8 irq after second rx", irq1, 1);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    #1 check("R8 irq cleared by ack", irq1, 0);
    port_read(8'd64, 16'h00C3, "R5 received C3");

    // R6: glitch shorter than half a bit
    skip = 1;
    rxd = 1'b0;
    wait_cyc(BIT / 4);
    rxd = 1'b1;
    wait_cyc(2 * BIT);
    skip = 0;
    check("R6 glitch no irq", irq1, 0);
    port_read(8'd64, 16'h00C3, "R6 glitch kept byte");

    // R7: bad stop bit
    send_rx(8'h11, 1'b0);
    check("R7 bad stop no irq", irq1, 0);
    port_read(8'd64, 16'h00C3, "R7 bad stop kept byte");

    // R7: receiver recovers after break
    send_rx(8'h96, 1'b1);
    port_read(8'd64, 16'h0096, "R7 recovery byte");

    // R9: unmapped port and write port read back zero
    port_read(8'd70, 0, "R9 unmapped port");
    port_read(8'd66, 0, "R9 write port reads zero");
    wait_cyc(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule